// File: doc/BRIEF.md
# Pipelined Burst SRAM Access Controller

This block is a pipelined synchronous SRAM with a single shared data bus and per-byte write lanes. All control inputs are captured on the rising clock edge. An access opens with one of two address strobes. The processor-side strobe (`adspN`) only takes effect while the first chip select is active. The controller-side strobe (`adscN`) is gated by all three selects together. Read data passes through an output register. It reaches the shared bus one edge after the access cycle, and the output enable acts combinationally on the bus driver. A two-bit burst counter steps the low address bits in either linear or interleaved order, so four words can be streamed from one captured address.

A write opened by the controller-side strobe commits in the same cycle as the strobe. A write opened by the processor-side strobe needs a second edge: the write controls and advance input are ignored in the first cycle, and the data is committed on the following edge. The bus driver is released whenever write controls are asserted, after a deselect, and on the first cycle of an access that follows a deselected period.

Top module: `burst_sram_ctrl`

## Requirements
- R1: After reset the device is deselected and `dq` is released (high impedance).
- R2: An edge with `adscN` low, `adspN` not taking effect and all of `cs0N`, `cs1N`, `cs2N` low starts an access. If write controls are asserted at that edge (`gwN` low, or `bweN` low with at least one `bwN` bit low), the `dq` value is stored at `addrIn` on that same edge.
- R3: A read access cycle at edge n puts the stored word on `dq` after edge n+1 while `oeN` is low.
- R4: In burst continuation cycles (`advN` low, no strobe), the two low address bits step through four positions starting at the captured address, and the upper bits stay fixed. With `linearMode`=1 step k gives base+k mod 4. With `linearMode`=0 it gives base XOR k. After four steps the sequence wraps back to the base.
- R5: An access started by `adspN` (all selects low) writes nothing at its first edge, whatever the write controls and `advN` are. If write controls are asserted at the second edge, `dq` is stored at the captured address, without advance.
- R6: `gwN` low writes all four byte lanes whatever `bweN`/`bwN` are. Otherwise, with `bweN` low, lane i (`dq[8i+7:8i]`) is written only when `bwN[i]` is low, and the other lanes keep their contents.
- R7: `adspN` low has no effect while `cs0N` is high; an ongoing burst continues as if the strobe were absent.
- R8: An edge where a taking-effect strobe sees any select inactive deselects the device, and `dq` is released right after that edge.
- R9: On the first cycle of an access that starts from the deselected state, `dq` stays released. Back-to-back accesses while selected keep delivering the previous read data.
- R10: `oeN` high releases `dq` immediately, without waiting for a clock edge.
- R11: While write controls are asserted, `dq` is released regardless of `oeN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addrIn | input | ADDR_W | Word address captured at access start |
| adspN | input | 1 | Processor-side address strobe, active low |
| adscN | input | 1 | Controller-side address strobe, active low |
| advN | input | 1 | Burst advance, active low |
| cs0N | input | 1 | First chip select (also gates `adspN`), active low |
| cs1N | input | 1 | Second chip select, active low |
| cs2N | input | 1 | Third chip select, active low |
| gwN | input | 1 | Global write, all lanes, active low |
| bweN | input | 1 | Byte-write enable, active low |
| bwN | input | DATA_W/8 | Per-lane write selects, active low |
| oeN | input | 1 | Asynchronous output enable, active low |
| linearMode | input | 1 | Burst order: 1 linear, 0 interleaved (static) |
| dq | inout | DATA_W | Shared bidirectional data bus |

## Verification
The hardest case to reach is a processor-strobe write whose first cycle carries asserted write controls, a driven bus and a low advance input. To show that all three are ignored, the stimulus drives a different data word in each of the two cycles and keeps advance low in both. Reading back the captured address and its neighbour then shows that only the second-cycle word landed, at the unadvanced address. A second hard case is the forced release after reselection. To tell it apart from ordinary pipelining, a deselected start is set against a back-to-back start, and both are preceded by a read that leaves valid data in the output register.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef struct packed {
    logic loadAddr;  // capture addrIn into the burst sequencer
    logic advance;   // step the burst counter this edge
    logic doWrite;   // commit bus data into the array this edge
    logic outLoad;   // load the output register this edge
    logic busBlock;  // write controls present: keep the bus released
  } ctrlStrobes_t;
endpackage

// File: rtl/sram_burst_seq.sv
module sram_burst_seq #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadAddr,
  input  logic              advance,
  input  logic              linearMode,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] curAddr,
  output logic [ADDR_W-1:0] accAddr
);
  localparam int LOW_W = 2;

  logic [ADDR_W-1:0] baseQ;
  logic [LOW_W-1:0]  cntQ;
  logic [LOW_W-1:0]  nextCnt;
  logic [ADDR_W-1:0] advAddr;

  function automatic logic [LOW_W-1:0] mixLow(input logic [LOW_W-1:0] base,
                                              input logic [LOW_W-1:0] step,
                                              input logic             lin);
    return lin ? (base + step) : (base ^ step);
  endfunction

  assign nextCnt = cntQ + LOW_W'(1);
  assign curAddr = {baseQ[ADDR_W-1:LOW_W], mixLow(baseQ[LOW_W-1:0], cntQ, linearMode)};
  assign advAddr = {baseQ[ADDR_W-1:LOW_W], mixLow(baseQ[LOW_W-1:0], nextCnt, linearMode)};

  always_comb begin
    if (loadAddr)     accAddr = addrIn;
    else if (advance) accAddr = advAddr;
    else              accAddr = curAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= '0;
      cntQ  <= '0;
    end else if (loadAddr) begin
      baseQ <= addrIn;
      cntQ  <= '0;
    end else if (advance) begin
      cntQ  <= nextCnt;
    end
  end
endmodule

// File: rtl/sram_access_ctrl.sv
module sram_access_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int BYTES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             adspN,
  input  logic             adscN,
  input  logic             advN,
  input  logic             cs0N,
  input  logic             cs1N,
  input  logic             cs2N,
  input  logic             gwN,
  input  logic             bweN,
  input  logic [BYTES-1:0] bwN,
  output ctrlStrobes_t     strb,
  output logic [BYTES-1:0] byteMask,
  output logic             isSelected
);
  logic selQ, adspPendQ, readSlotQ;
  logic adspEff, adscEff, allSel, startP, startC, desel, cont, wrReq, readSlotD;

  assign adspEff = !adspN && !cs0N;
  assign adscEff = !adscN && !adspEff;
  assign allSel  = !cs0N && !cs1N && !cs2N;
  assign startP  = adspEff && allSel;
  assign startC  = adscEff && allSel;
  assign desel   = (adspEff || adscEff) && !allSel;
  assign cont    = selQ && !adspEff && !adscEff;
  assign wrReq   = !gwN || (!bweN && !(&bwN));

  always_comb begin
    if (!gwN)       byteMask = '1;
    else if (!bweN) byteMask = ~bwN;
    else            byteMask = '0;
  end

  always_comb begin
    strb.loadAddr = startP || startC;
    strb.doWrite  = (startC || cont) && wrReq;
    strb.advance  = cont && !advN && !adspPendQ;
    strb.outLoad  = readSlotQ && !strb.doWrite && !desel;
    strb.busBlock = wrReq;
    readSlotD     = startP || ((startC || cont) && !wrReq);
  end

  assign isSelected = selQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ      <= 1'b0;
      adspPendQ <= 1'b0;
      readSlotQ <= 1'b0;
    end else begin
      if (startP || startC) selQ <= 1'b1;
      else if (desel)       selQ <= 1'b0;
      adspPendQ <= startP;
      readSlotQ <= readSlotD;
    end
  end
endmodule

// File: rtl/sram_datapath.sv
module sram_datapath
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobes_t           strb,
  input  logic [DATA_W/8-1:0]    byteMask,
  input  logic                   linearMode,
  input  logic                   oeN,
  input  logic [ADDR_W-1:0]      addrIn,
  input  logic [DATA_W-1:0]      wrData,
  output logic [DATA_W-1:0]      rdWord,
  output logic                   busEn
);
  localparam int BYTES = DATA_W / 8;
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] curAddr, accAddr;
  logic [DATA_W-1:0] rdRaw;
  logic              outValidQ;

  sram_burst_seq #(.ADDR_W(ADDR_W)) i_seq (
    .clk(clk), .rstN(rstN), .loadAddr(strb.loadAddr), .advance(strb.advance),
    .linearMode(linearMode), .addrIn(addrIn), .curAddr(curAddr), .accAddr(accAddr)
  );

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    logic [7:0] laneMem [DEPTH];
    always_ff @(posedge clk) begin
      if (strb.doWrite && byteMask[b]) laneMem[accAddr] <= wrData[8*b +: 8];
    end
    assign rdRaw[8*b +: 8] = laneMem[curAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValidQ <= 1'b0;
      rdWord    <= '0;
    end else begin
      outValidQ <= strb.outLoad;
      if (strb.outLoad) rdWord <= rdRaw;
    end
  end

  assign busEn = outValidQ && !oeN && !strb.busBlock;
endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addrIn,
  input  logic                adspN,
  input  logic                adscN,
  input  logic                advN,
  input  logic                cs0N,
  input  logic                cs1N,
  input  logic                cs2N,
  input  logic                gwN,
  input  logic                bweN,
  input  logic [DATA_W/8-1:0] bwN,
  input  logic                oeN,
  input  logic                linearMode,
  inout  wire  [DATA_W-1:0]   dq
);
  localparam int BYTES = DATA_W / 8;

  ctrlStrobes_t      strb;
  logic [BYTES-1:0]  byteMask;
  logic              isSelected;
  logic              busEn;
  logic [DATA_W-1:0] rdWord;

  sram_access_ctrl #(.BYTES(BYTES)) i_ctrl (
    .clk(clk), .rstN(rstN), .adspN(adspN), .adscN(adscN), .advN(advN),
    .cs0N(cs0N), .cs1N(cs1N), .cs2N(cs2N), .gwN(gwN), .bweN(bweN), .bwN(bwN),
    .strb(strb), .byteMask(byteMask), .isSelected(isSelected)
  );

  sram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .byteMask(byteMask),
    .linearMode(linearMode), .oeN(oeN), .addrIn(addrIn), .wrData(dq),
    .rdWord(rdWord), .busEn(busEn)
  );

  assign dq = busEn ? rdWord : {DATA_W{1'bz}};
endmodule

// File: rtl/sram_bus_checker.sv
module sram_bus_checker #(
  parameter int BYTES = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             adspN,
  input logic             adscN,
  input logic             cs0N,
  input logic             cs1N,
  input logic             cs2N,
  input logic             gwN,
  input logic             bweN,
  input logic [BYTES-1:0] bwN,
  input logic             oeN,
  input logic             busEn,
  input logic             isSelected
);
  logic pEff, cEff, allOn, deselEdge, startAny, wrSeen;
  assign pEff      = !adspN && !cs0N;
  assign cEff      = !adscN && !pEff;
  assign allOn     = !cs0N && !cs1N && !cs2N;
  assign deselEdge = (pEff || cEff) && !allOn;
  assign startAny  = (pEff || cEff) && allOn;
  assign wrSeen    = !gwN || (!bweN && !(&bwN));

  // R8
  desel_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    deselEdge |=> !busEn);
  // R9
  reselect_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!isSelected && startAny) |=> !busEn);
  // R10
  oe_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> !busEn);
  // R11
  write_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrSeen |-> !busEn);
endmodule

bind burst_sram_ctrl sram_bus_checker #(.BYTES(DATA_W/8)) i_busChk (
  .clk(clk), .rstN(rstN), .adspN(adspN), .adscN(adscN), .cs0N(cs0N),
  .cs1N(cs1N), .cs2N(cs2N), .gwN(gwN), .bweN(bweN), .bwN(bwN), .oeN(oeN),
  .busEn(busEn), .isSelected(isSelected)
);

// File: tb/test_burst_sram_ctrl.sv
module test_burst_sram_ctrl;
  localparam int AW = 6;
  localparam int DW = 32;

  logic clk = 1'b0, rstN = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic adspN = 1, adscN = 1, advN = 1, cs0N = 0, cs1N = 0, cs2N = 0;
  logic gwN = 1, bweN = 1, oeN = 0, linearMode = 1;
  logic [3:0] bwN = 4'hF;
  logic tbDrv = 0;
  logic [DW-1:0] tbData = '0;
  wire  [DW-1:0] dq;
  logic [DW-1:0] model [1<<AW];
  int totalCnt = 0, failCnt = 0;

  assign dq = tbDrv ? tbData : {DW{1'bz}};
  for (genvar i = 0; i < DW; i++) begin : g_pu
    pullup (dq[i]);
  end

  burst_sram_ctrl #(.ADDR_W(AW), .DATA_W(DW)) i_burst_sram_ctrl (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .adspN(adspN), .adscN(adscN),
    .advN(advN), .cs0N(cs0N), .cs1N(cs1N), .cs2N(cs2N), .gwN(gwN), .bweN(bweN),
    .bwN(bwN), .oeN(oeN), .linearMode(linearMode), .dq(dq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    totalCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chkFloat(input string req);
    chk(req, dq, {DW{1'b1}});
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    adspN = 1; adscN = 1; advN = 1; cs0N = 0; cs1N = 0; cs2N = 0;
    gwN = 1; bweN = 1; bwN = 4'hF; oeN = 0; tbDrv = 0;
  endtask

  function automatic logic [AW-1:0] seqAddr(input logic [AW-1:0] b, input int k, input logic lin);
    logic [1:0] s = 2'(k);
    return {b[AW-1:2], lin ? (b[1:0] + s) : (b[1:0] ^ s)};
  endfunction

  // R2: controller-strobe write stores dq at addrIn on the strobe edge
  task automatic adscWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    idle(); adscN = 0; addrIn = a; gwN = 0; tbDrv = 1; tbData = d;
    tick(); model[a] = d; idle();
  endtask

  // R3, R4: start read, stream five beats with advN low
  task automatic readBurst(input logic [AW-1:0] b, input logic lin, input string req);
    idle(); linearMode = lin; adscN = 0; addrIn = b;
    tick();
    idle(); advN = 0;
    for (int k = 0; k < 5; k++) begin
      tick();
      chk(req, dq, model[seqAddr(b, k, lin)]);
    end
    idle();
  endtask

  task automatic testReset();
    idle();
    rstN = 0; tick(); tick();
    rstN = 1; tick();
    chkFloat("R1 reset float");
  endtask

  task automatic testWriteRead();
    for (int i = 0; i < 4; i++) adscWrite(AW'(8 + i), 32'h1000_0000 + i);
    adscWrite(6'd40, 32'h4040_4040);
    adscWrite(6'd20, 32'h2020_2020);
    adscWrite(6'd21, 32'h2121_2121);
    // R3: one-edge pipeline
    idle(); adscN = 0; addrIn = 6'd10; tick();
    idle(); tick();
    chk("R3 read latency", dq, model[10]);
    readBurst(6'd8, 1'b1, "R2/R4 linear from 8");
  endtask

  task automatic testBurstOrders();
    readBurst(6'd9, 1'b1, "R4 linear from 9");
    readBurst(6'd9, 1'b0, "R4 interleaved from 9");
    readBurst(6'd10, 1'b0, "R4 interleaved from 10");
  endtask

  task automatic testByteWrite();
    adscWrite(6'd9, 32'h1122_3344);
    idle(); adscN = 0; addrIn = 6'd9; bweN = 0; bwN = 4'b1010;
    tbDrv = 1; tbData = 32'hAABB_CCDD; tick(); idle();
    model[9] = 32'h11BB_33DD;
    idle(); adscN = 0; addrIn = 6'd9; tick(); idle(); tick();
    chk("R6 byte lanes 0,2", dq, model[9]);
    // R6: global write overrides disabled byte controls
    idle(); adscN = 0; addrIn = 6'd9; gwN = 0; bweN = 1; bwN = 4'hF;
    tbDrv = 1; tbData = 32'h5A5A_5A5A; tick(); idle();
    model[9] = 32'h5A5A_5A5A;
    idle(); adscN = 0; addrIn = 6'd9; tick(); idle(); tick();
    chk("R6 global override", dq, model[9]);
  endtask

  task automatic testAdspWrite();
    // R5: first edge ignores write controls, advN and data
    idle(); adspN = 0; addrIn = 6'd20; gwN = 0; advN = 0;
    tbDrv = 1; tbData = 32'hDEAD_0001; tick();
    idle(); gwN = 0; advN = 0; tbDrv = 1; tbData = 32'hBEEF_0002; tick();
    model[20] = 32'hBEEF_0002;
    idle(); adscN = 0; addrIn = 6'd20; tick(); idle(); tick();
    chk("R5 second-edge data at captured addr", dq, model[20]);
    idle(); adscN = 0; addrIn = 6'd21; tick(); idle(); tick();
    chk("R5 neighbour untouched", dq, model[21]);
  endtask

  task automatic testAdspIgnored();
    idle(); linearMode = 1; adscN = 0; addrIn = 6'd8; tick();
    idle(); advN = 0; adspN = 0; cs0N = 1; addrIn = 6'd40; tick();
    chk("R7 beat 0", dq, model[8]);
    idle(); advN = 0; tick();
    chk("R7 burst continues", dq, model[9]);
    idle();
  endtask

  task automatic testDeselReselect();
    idle(); adscN = 0; addrIn = 6'd10; tick(); idle(); tick();
    chk("R8 pre-check data", dq, model[10]);
    idle(); adscN = 0; cs1N = 1; tick(); idle();
    chkFloat("R8 deselect float");
    tick();
    chkFloat("R8 stays float");
    idle(); adscN = 0; addrIn = 6'd8; tick(); idle();
    chkFloat("R9 first cycle after reselect");
    tick();
    chk("R9 data next", dq, model[8]);
    idle(); adscN = 0; addrIn = 6'd9; tick(); idle();
    chk("R9 back-to-back keeps data", dq, model[8]);
    tick();
    chk("R9 second read", dq, model[9]);
  endtask

  task automatic testBusRelease();
    idle(); adscN = 0; addrIn = 6'd21; tick(); idle(); tick();
    chk("R10 data before", dq, model[21]);
    oeN = 1; #1;
    chkFloat("R10 oe high float");
    oeN = 0; #1;
    chk("R10 oe low data", dq, model[21]);
    gwN = 0; #1;
    chkFloat("R11 global write float");
    gwN = 1; bweN = 0; bwN = 4'b1110; #1;
    chkFloat("R11 byte write float");
    bweN = 1; bwN = 4'hF; #1;
    chk("R11 released back", dq, model[21]);
    idle();
  endtask

  initial begin
    #1_500_000;
    totalCnt++; failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

  initial begin
    testReset();
    testWriteRead();
    testBurstOrders();
    testByteWrite();
    testAdspWrite();
    testAdspIgnored();
    testDeselReselect();
    testBusRelease();
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end
endmodule